// File: doc/BRIEF.md
# Frame Sync Superframe Detector

This block watches an active-high frame sync line, sampled on the rising edge of the TDM data clock, and sorts each sync pulse by its width. A pulse two clocks wide starts an ordinary 125 µs frame. A pulse one clock wide starts a frame and also marks a superframe boundary. At 8 kHz framing these boundaries recur every 96 frames, or 12 ms. The block reports a one-cycle frame-start strobe in the cycle that carries the first B-channel bit. It also reports a superframe strobe, a frame index within the superframe, and three error strobes: bad pulse width, bad frame period and bad superframe placement.

Lock is declared only after two consecutive frame intervals of exactly `CLKS_PER_FRAME` data clocks. Until then every strobe and period or superframe error stays low. A frame interval of any other length, once locked, reports a period error and drops lock. The superframe index counts only while locked. It aligns to the first one-clock pulse seen after lock and then checks where each later mark falls.

Top module: `fsync_sf_detector`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, every strobe output, `locked` and `frame_idx` are 0.
- R2: A rising sync pulse is one whose first high sample follows a low sample. In the cycle after that first high sample, `frame_start` is high for one cycle, but only when `locked` is high and the interval since the previous rising pulse is exactly `CLKS_PER_FRAME` clocks.
- R3: `locked` rises in the cycle after the rising pulse that completes two consecutive intervals of exactly `CLKS_PER_FRAME`. While `locked` is low, `frame_start` and `sf_start` stay low.
- R4: While locked, a rising pulse after an interval other than `CLKS_PER_FRAME` raises `err_period` for one cycle instead of `frame_start`, and `locked` is low from the next cycle on.
- R5: On the third consecutive high sample of one pulse, `err_width` is high for one cycle in the following cycle, whether or not the block is locked. Longer pulses raise it only once.
- R6: A one-clock pulse is one high sample between two low samples. While locked, if no mark has yet been accepted or `frame_idx` is 0, such a pulse raises `sf_start` for one cycle in the cycle after its low sample, and `frame_idx` is 0 afterwards.
- R7: While locked, each `frame_start` advances `frame_idx` by one in the next cycle, wrapping from `FRAMES_PER_SF-1` to 0.
- R8: Once a mark has been accepted, a one-clock pulse arriving while `frame_idx` is not 0 raises `err_sf` instead of `sf_start`, and realigns `frame_idx` to 0.
- R9: Once a mark has been accepted, a two-clock pulse that ends while `frame_idx` is 0 raises `err_sf` for one cycle, because the expected mark is missing.
- R10: While `locked` is low, `frame_idx` is 0 in the following cycle, and the accepted-mark state is forgotten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | TDM data clock; sync is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Active-high frame sync |
| frame_start | output | 1 | One-cycle strobe on the first B-channel bit of a locked frame |
| sf_start | output | 1 | One-cycle strobe for an accepted superframe mark |
| frame_idx | output | $clog2(FRAMES_PER_SF) | Frame number within the superframe |
| locked | output | 1 | Frame period lock |
| err_width | output | 1 | Sync pulse longer than two clocks |
| err_period | output | 1 | Frame interval other than `CLKS_PER_FRAME` while locked |
| err_sf | output | 1 | Superframe mark early, late or missing |

## Verification
A corrupted width count shows one clock after the sync falls. It appears as a misclassified pulse: a missing `sf_start` or a spurious `err_sf`. A wrong period count or lock state shows at the next rising sync, within one frame, as a missing `frame_start` or a false `err_period`. A drifting frame index can stay hidden for up to 96 frames. It surfaces only when the next mark lands or is missed, so the stimulus runs through full superframes with marks placed both on time and off time.

// File: rtl/fsync_sf_pkg.sv
package fsync_sf_pkg;

  // Saturating increment for an unsigned counter of width W.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input int unsigned max_v);
    return (v >= max_v) ? max_v : v + 32'd1;
  endfunction

  // Modulo increment: wraps to zero after the last index.
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input int unsigned count);
    return (v >= count - 1) ? 32'd0 : v + 32'd1;
  endfunction

  // Interval check between consecutive rising sync pulses.
  function automatic logic period_match(input logic [31:0] measured, input int unsigned nominal);
    return measured == nominal;
  endfunction

  // Widths a sync pulse may carry.
  typedef enum logic [1:0] {
    W_NONE   = 2'd0,
    W_MARK   = 2'd1,
    W_NORMAL = 2'd2,
    W_LONG   = 2'd3
  } pulse_width_e;

endpackage

// File: rtl/fsd_pulse_sampler.sv
module fsd_pulse_sampler
  import fsync_sf_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fsync,
  output logic         rise,
  output logic         fall,
  output pulse_width_e width,
  output logic         too_long
);

  logic         smp_now;
  logic         smp_prev;
  pulse_width_e run_q;
  logic         long_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_now  <= 1'b0;
      smp_prev <= 1'b0;
      run_q    <= W_NONE;
      long_q   <= 1'b0;
    end else begin
      smp_now  <= fsync;
      smp_prev <= smp_now;
      long_q   <= fsync && smp_now && (run_q == W_NORMAL);
      if (fsync) begin
        if (smp_now)
          run_q <= pulse_width_e'(sat_inc(32'(run_q), 3));
        else
          run_q <= W_MARK;
      end
    end
  end

  assign rise     = smp_now && !smp_prev;
  assign fall     = !smp_now && smp_prev;
  assign width    = run_q;
  assign too_long = long_q;

endmodule

// File: rtl/fsd_period_lock.sv
module fsd_period_lock
  import fsync_sf_pkg::*;
#(
  parameter int unsigned CLKS_PER_FRAME = 64,
  parameter int unsigned GOOD_TO_LOCK   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic period_ok,
  output logic locked
);

  localparam int unsigned PW    = $clog2(CLKS_PER_FRAME + 1) + 1;
  localparam int unsigned PMAX  = (1 << PW) - 1;
  localparam int unsigned GW    = $clog2(GOOD_TO_LOCK + 1);

  logic [PW-1:0] gap_q;
  logic [GW-1:0] good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= PW'(PMAX);
      good_q <= '0;
    end else if (rise) begin
      gap_q  <= PW'(1);
      if (period_ok)
        good_q <= GW'(sat_inc(32'(good_q), GOOD_TO_LOCK));
      else
        good_q <= '0;
    end else begin
      gap_q <= PW'(sat_inc(32'(gap_q), PMAX));
    end
  end

  assign period_ok = period_match(32'(gap_q), CLKS_PER_FRAME);
  assign locked    = (32'(good_q) == GOOD_TO_LOCK);

endmodule

// File: rtl/fsd_sf_counter.sv
module fsd_sf_counter
  import fsync_sf_pkg::*;
#(
  parameter int unsigned FRAMES_PER_SF = 96,
  localparam int unsigned IW = $clog2(FRAMES_PER_SF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          locked,
  input  logic          frame_start,
  input  logic          mark_end,
  input  logic          pair_end,
  output logic [IW-1:0] frame_idx,
  output logic          sf_start,
  output logic          sf_err
);

  logic [IW-1:0] idx_q;
  logic          aligned_q;
  logic          mark_ok;
  logic          at_zero;

  assign at_zero  = (idx_q == '0);
  assign mark_ok  = mark_end && locked;
  assign sf_start = mark_ok && (!aligned_q || at_zero);
  assign sf_err   = (mark_ok && aligned_q && !at_zero)
                 || (pair_end && locked && aligned_q && at_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      aligned_q <= 1'b0;
    end else if (!locked) begin
      idx_q     <= '0;
      aligned_q <= 1'b0;
    end else if (mark_ok) begin
      idx_q     <= '0;
      aligned_q <= 1'b1;
    end else if (frame_start) begin
      idx_q <= IW'(wrap_inc(32'(idx_q), FRAMES_PER_SF));
    end
  end

  assign frame_idx = idx_q;

endmodule

// File: rtl/fsync_sf_detector.sv
module fsync_sf_detector
  import fsync_sf_pkg::*;
#(
  parameter int unsigned CLKS_PER_FRAME = 64,
  parameter int unsigned FRAMES_PER_SF  = 96,
  localparam int unsigned IW = $clog2(FRAMES_PER_SF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  output logic          frame_start,
  output logic          sf_start,
  output logic [IW-1:0] frame_idx,
  output logic          locked,
  output logic          err_width,
  output logic          err_period,
  output logic          err_sf
);

  logic         ev_rise;
  logic         ev_fall;
  pulse_width_e ev_width;
  logic         ev_period_ok;
  logic         ev_mark_end;
  logic         ev_pair_end;

  fsd_pulse_sampler u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .rise     (ev_rise),
    .fall     (ev_fall),
    .width    (ev_width),
    .too_long (err_width)
  );

  fsd_period_lock #(
    .CLKS_PER_FRAME (CLKS_PER_FRAME),
    .GOOD_TO_LOCK   (2)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (ev_rise),
    .period_ok (ev_period_ok),
    .locked    (locked)
  );

  assign frame_start = ev_rise && locked && ev_period_ok;
  assign err_period  = ev_rise && locked && !ev_period_ok;
  assign ev_mark_end = ev_fall && (ev_width == W_MARK);
  assign ev_pair_end = ev_fall && (ev_width == W_NORMAL);

  fsd_sf_counter #(
    .FRAMES_PER_SF (FRAMES_PER_SF)
  ) u_sf (
    .clk         (clk),
    .rst_n       (rst_n),
    .locked      (locked),
    .frame_start (frame_start),
    .mark_end    (ev_mark_end),
    .pair_end    (ev_pair_end),
    .frame_idx   (frame_idx),
    .sf_start    (sf_start),
    .sf_err      (err_sf)
  );

endmodule

// File: rtl/fsync_sf_checker.sv
module fsync_sf_checker #(
  parameter int unsigned FRAMES = 96,
  localparam int unsigned IW = $clog2(FRAMES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          sf_start,
  input logic [IW-1:0] frame_idx,
  input logic          locked,
  input logic          err_width,
  input logic          err_period,
  input logic          ev_rise,
  input logic          ev_fall
);

  // R3: no strobe without lock
  a_r3_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!frame_start && !sf_start));

  // R2: frame strobe only on a rising sync
  a_r2_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ev_rise);

  // R4: period error drops lock
  a_r4_err_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    err_period |=> !locked);

  // R5: width error lasts one cycle per pulse
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    err_width |=> !err_width);

  // R6: accepted mark clears the index
  a_r6_mark_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |=> (frame_idx == '0));

  // R6: marks are read on the falling sample only
  a_r6_mark_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |-> ev_fall);

  // R7: index stays in range
  a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frame_idx) < FRAMES);

  // R7: index advances by one per frame strobe
  a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ((32'(frame_idx) == 32'(($past(frame_idx)) + 1))
                    || (frame_idx == '0 && 32'($past(frame_idx)) == FRAMES - 1)));

  // R10: index held at zero while unlocked
  a_r10_idx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> (frame_idx == '0));

  // R2 R6: frame and superframe strobes never coincide
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_start, sf_start}));

endmodule

bind fsync_sf_detector fsync_sf_checker #(.FRAMES(FRAMES_PER_SF)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .sf_start    (sf_start),
  .frame_idx   (frame_idx),
  .locked      (locked),
  .err_width   (err_width),
  .err_period  (err_period),
  .ev_rise     (ev_rise),
  .ev_fall     (ev_fall)
);

// File: tb/sim_fsync_sf_detector.sv
module sim_fsync_sf_detector;

  localparam int P  = 64;
  localparam int F  = 96;
  localparam int IW = $clog2(F);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fsync = 1'b0;
  logic          frame_start, sf_start, locked, err_width, err_period, err_sf;
  logic [IW-1:0] frame_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fsync_sf_detector #(.CLKS_PER_FRAME(P), .FRAMES_PER_SF(F)) u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .frame_start(frame_start), .sf_start(sf_start), .frame_idx(frame_idx),
    .locked(locked), .err_width(err_width), .err_period(err_period), .err_sf(err_sf)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, in terms of sampled pulse events
  int  e_num, last_rise_e, run, good, idx;
  bit  prev_s, lock_m, aligned;
  bit  d_rise, d_okp, d_fs, d_mark;
  bit  x_fs, x_sf, x_perr, x_werr, x_sferr;

  function automatic int next_idx(input int i);
    return (i + 1) % F;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_num = 0; last_rise_e = -100000; run = 0; good = 0; idx = 0;
      prev_s = 0; lock_m = 0; aligned = 0;
      d_rise = 0; d_okp = 0; d_fs = 0; d_mark = 0;
      x_fs = 0; x_sf = 0; x_perr = 0; x_werr = 0; x_sferr = 0;
    end else begin
      bit x, rise, fall, marker;
      int gap;
      x = fsync;
      // effects of the previous cycle's events
      if (!lock_m) begin idx = 0; aligned = 0; end
      else if (d_mark) begin idx = 0; aligned = 1; end
      else if (d_fs) idx = next_idx(idx);
      if (d_rise) begin
        good = d_okp ? ((good >= 2) ? 2 : good + 1) : 0;
        lock_m = (good == 2);
      end
      // events seen at this edge
      rise = x && !prev_s;
      fall = !x && prev_s;
      gap  = e_num - last_rise_e;
      x_werr = x && prev_s && (run == 2);
      x_fs   = rise && lock_m && (gap == P);
      x_perr = rise && lock_m && (gap != P);
      marker = fall && (run == 1) && lock_m;
      x_sf   = marker && (!aligned || idx == 0);
      x_sferr = (marker && aligned && idx != 0)
             || (fall && run == 2 && lock_m && aligned && idx == 0);
      if (x) run = prev_s ? ((run >= 3) ? 3 : run + 1) : 1;
      if (rise) last_rise_e = e_num;
      d_rise = rise; d_okp = (gap == P); d_fs = x_fs; d_mark = marker;
      prev_s = x;
      e_num++;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 frame_start", int'(frame_start), int'(x_fs));
      check("R3 locked", int'(locked), int'(lock_m));
      check("R4 err_period", int'(err_period), int'(x_perr));
      check("R5 err_width", int'(err_width), int'(x_werr));
      check("R6 sf_start", int'(sf_start), int'(x_sf));
      check("R7 R10 frame_idx", int'(frame_idx), idx);
      check("R8 R9 err_sf", int'(err_sf), int'(x_sferr));
    end
  end

  task automatic send_pulse(input int w, input int per);
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      fsync = (i < w);
    end
  endtask

  task automatic normal_frames(input int n);
    for (int i = 0; i < n; i++) send_pulse(2, P);
  endtask

  int seen_sferr;
  always @(negedge clk) if (rst_n && err_sf) seen_sferr++;

  initial begin
    void'($urandom(32'd20240517));
    seen_sferr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset strobes", int'({frame_start, sf_start, err_width, err_period, err_sf}), 0);
    check("R1 reset lock/idx", int'(locked) + int'(frame_idx), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", int'({frame_start, sf_start, locked, err_sf}), 0);

    // R3: lock after two good intervals
    normal_frames(3);
    check("R3 locked after three pulses", int'(locked), 1);

    // R6: first mark accepted, then a full superframe to the next mark
    send_pulse(1, P);
    check("R6 idx after mark", int'(frame_idx), 0);
    normal_frames(F - 1);
    check("R7 idx before wrap", int'(frame_idx), F - 1);
    send_pulse(1, P);
    check("R6 idx after on-time mark", int'(frame_idx), 0);

    // R8: early mark
    normal_frames(10);
    seen_sferr = 0;
    send_pulse(1, P);
    check("R8 early mark flagged", int'(seen_sferr > 0), 1);
    check("R8 realigned", int'(frame_idx), 0);

    // R9: missing mark at index 0
    normal_frames(F - 1);
    seen_sferr = 0;
    send_pulse(2, P);
    check("R9 missing mark flagged", int'(seen_sferr > 0), 1);

    // R5: long pulses
    send_pulse(3, P);
    send_pulse(5, P);

    // R4 R10: late frame, then relock
    send_pulse(2, P + 2);
    send_pulse(2, P);
    check("R4 lock dropped", int'(locked), 0);
    check("R10 idx cleared", int'(frame_idx), 0);
    normal_frames(3);
    check("R3 relocked", int'(locked), 1);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 70)      send_pulse(2, P);
      else if (r < 80) send_pulse(1, P);
      else if (r < 88) send_pulse(3 + int'($urandom % 3), P);
      else begin
        int d;
        d = int'($urandom % 6) - 3;
        if (d >= 0) d++;
        send_pulse(2, P + d);
      end
    end
    normal_frames(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule